// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Page Permissions

This block is a small, fully associative cache of address translations. It maps a virtual page number to a physical frame number without consulting a page table. Every entry is tagged with an address-space identifier, so translations belonging to several processes can be held at once and no flush is needed on a context switch.

Every entry also holds a permission code. Each hit is checked against the requested access kind, which is a read, a write or an instruction fetch. An access the page does not allow is reported as a protection fault rather than a hit.

The block has three request paths:
- A lookup port. Its registered answer appears one cycle after the request.
- A fill port. It installs a translation after a miss.
- Flush controls. They drop every entry, or only the entries of one identifier.

When the table is full, a mode input selects how the victim is chosen: least-recently-used, or a pseudo-random pick from a free-running shift register.

Top module: `tlb_asid`

## Requirements
- R1: A lookup accepted on a clock edge (`lookup_valid`=1) raises `rsp_valid` for exactly the following cycle. A cycle with no lookup leaves `rsp_valid`, `rsp_hit` and `rsp_fault` at 0 in the next cycle.
- R2: A lookup hits only when a valid entry matches both the page number and the identifier. A hit returns that entry's frame number on `rsp_pfn`. A miss reports `rsp_hit`=0 and `rsp_fault`=0 with `rsp_pfn`=0.
- R3: Two entries with the same page number but different identifiers coexist. Each one answers only lookups that carry its own identifier.
- R4: Permission codes are 0 read-write, 1 read-only, 2 execute-only and 3 no access. Access codes are 0 read, 1 write and 2 fetch; access code 3 is allowed by no permission. Read-write allows read and write. Read-only allows read. Execute-only allows fetch. On a matching entry that does not allow the access, the response is `rsp_fault`=1, `rsp_hit`=0 and `rsp_pfn`=0. `rsp_hit` and `rsp_fault` are never both 1.
- R5: A fill whose page number and identifier already sit in a valid entry overwrites that entry, so no pair is ever held twice. Any other fill goes to the lowest-numbered invalid entry if one exists.
- R6: With `repl_mode`=0 and all entries valid, a new fill replaces the entry least recently hit or filled.
- R7: With `repl_mode`=1 and all entries valid, a new fill replaces exactly one existing entry, chosen by a 4-bit pseudo-random register that advances every cycle.
- R8: `flush_all` invalidates every entry in one cycle. Lookups from the next cycle miss.
- R9: `flush_asid_en` invalidates only the entries whose identifier equals `flush_asid`. All other entries keep hitting.
- R10: A fill and a lookup in the same cycle: the fill is performed, and the lookup reports `rsp_valid`=1 with `rsp_hit`=0 and `rsp_fault`=0.
- R11: After reset no entry is valid, all response outputs are 0, and any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookup_valid | input | 1 | Lookup request strobe |
| lookup_vpn | input | 20 | Virtual page number to translate |
| lookup_asid | input | 8 | Identifier of the requesting address space |
| lookup_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| fill_valid | input | 1 | Fill request strobe |
| fill_vpn | input | 20 | Page number of the new translation |
| fill_asid | input | 8 | Identifier of the new translation |
| fill_pfn | input | 20 | Frame number of the new translation |
| fill_perm | input | 2 | Permission code of the new translation |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | 8 | Identifier to invalidate |
| repl_mode | input | 1 | Replacement policy: 0 least-recently-used, 1 pseudo-random |
| rsp_valid | output | 1 | Response present for last cycle's lookup |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Translation found but access denied |
| rsp_pfn | output | 20 | Frame number on a hit, 0 otherwise |

## Verification
The assertions check several rules on every cycle:
- the response only ever follows a lookup, and a hit never coincides with a fault;
- a lookup that collides with a fill always reports a plain miss;
- flush-all leaves no valid entry;
- at most one entry matches any lookup;
- the recency ages always name exactly one oldest entry, and the random register never reaches zero.

Only the bench scenarios can show which entry a full table gives up, which one survives a flush by identifier, how entries with the same page number but different identifiers stay apart, and the result of each permission and access pairing.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        PERM_RW   = 2'd0,
        PERM_RO   = 2'd1,
        PERM_XO   = 2'd2,
        PERM_NONE = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_BAD   = 2'd3
    } acc_e;

    function automatic logic perm_allows(input perm_e perm, input acc_e acc);
        logic ok;
        case (perm)
            PERM_RW: ok = (acc == ACC_READ) || (acc == ACC_WRITE);
            PERM_RO: ok = (acc == ACC_READ);
            PERM_XO: ok = (acc == ACC_FETCH);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] tag_asid,
    input  logic [VPN_W-1:0]               lk_vpn,
    input  logic [ASID_W-1:0]              lk_asid,
    input  logic [VPN_W-1:0]               fl_vpn,
    input  logic [ASID_W-1:0]              fl_asid,
    input  logic [ASID_W-1:0]              fa_asid,
    output logic [ENTRIES-1:0]             lk_match,
    output logic [ENTRIES-1:0]             fl_match,
    output logic [ENTRIES-1:0]             asid_match
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign lk_match[i]   = valid[i] && (tag_vpn[i] == lk_vpn) && (tag_asid[i] == lk_asid);
        assign fl_match[i]   = valid[i] && (tag_vpn[i] == fl_vpn) && (tag_asid[i] == fl_asid);
        assign asid_match[i] = (tag_asid[i] == fa_asid);
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int              ENTRIES   = 16,
    parameter int              LFSR_W    = 4,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 4'b1100,
    localparam int             IDX_W     = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               repl_mode,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    output logic [IDX_W-1:0]   victim_idx
);

    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
        logic [LFSR_W-1:0]             lfsr;
    } vstate_t;

    vstate_t st_d, st_q;
    logic [ENTRIES-1:0] oldest_vec;
    logic [IDX_W-1:0]   free_idx, lru_idx;
    logic               any_free;

    always_comb begin
        st_d = st_q;
        st_d.lfsr = (st_q.lfsr >> 1) ^ (st_q.lfsr[0] ? LFSR_TAPS : '0);
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    st_d.age[i] = '0;
                end else if (st_q.age[i] < st_q.age[touch_idx]) begin
                    st_d.age[i] = st_q.age[i] + 1'b1;
                end
            end
        end

        any_free = 1'b0;
        free_idx = '0;
        lru_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            oldest_vec[i] = (st_q.age[i] == IDX_W'(ENTRIES - 1));
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (oldest_vec[i]) lru_idx = IDX_W'(i);
        end

        if (any_free)       victim_idx = free_idx;
        else if (repl_mode) victim_idx = st_q.lfsr[IDX_W-1:0];
        else                victim_idx = lru_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) st_q.age[i] <= IDX_W'(i);
            st_q.lfsr <= LFSR_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1); // R6
    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0); // R7

endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int LFSR_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic [VPN_W-1:0]  lookup_vpn,
    input  logic [ASID_W-1:0] lookup_asid,
    input  logic [1:0]        lookup_acc,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_perm,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              repl_mode,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn
);

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        perm_e             perm;
    } entry_t;

    typedef struct packed {
        logic [ENTRIES-1:0]        valid;
        entry_t [ENTRIES-1:0]      ent;
        logic                      rsp_valid;
        logic                      rsp_hit;
        logic                      rsp_fault;
        logic [PFN_W-1:0]          rsp_pfn;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0] tag_asid;
    logic [ENTRIES-1:0]             lk_match, fl_match, asid_match;
    logic [IDX_W-1:0]               victim_idx, hit_idx, dup_idx, wr_idx;
    logic                           touch;
    logic [IDX_W-1:0]               touch_idx;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tags
        assign tag_vpn[i]  = st_q.ent[i].vpn;
        assign tag_asid[i] = st_q.ent[i].asid;
    end

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
        .valid      (st_q.valid),
        .tag_vpn    (tag_vpn),
        .tag_asid   (tag_asid),
        .lk_vpn     (lookup_vpn),
        .lk_asid    (lookup_asid),
        .fl_vpn     (fill_vpn),
        .fl_asid    (fill_asid),
        .fa_asid    (flush_asid),
        .lk_match   (lk_match),
        .fl_match   (fl_match),
        .asid_match (asid_match)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .LFSR_W(LFSR_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (st_q.valid),
        .repl_mode  (repl_mode),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    always_comb begin
        logic allowed;
        st_d = st_q;

        hit_idx = '0;
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) hit_idx = IDX_W'(i);
            if (fl_match[i]) dup_idx = IDX_W'(i);
        end
        wr_idx  = (|fl_match) ? dup_idx : victim_idx;
        allowed = perm_allows(st_q.ent[hit_idx].perm, acc_e'(lookup_acc));

        st_d.rsp_valid = lookup_valid;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_fault = 1'b0;
        st_d.rsp_pfn   = '0;
        if (lookup_valid && !fill_valid && (|lk_match)) begin
            if (allowed) begin
                st_d.rsp_hit = 1'b1;
                st_d.rsp_pfn = st_q.ent[hit_idx].pfn;
            end else begin
                st_d.rsp_fault = 1'b1;
            end
        end

        touch     = fill_valid || (lookup_valid && (|lk_match) && allowed);
        touch_idx = fill_valid ? wr_idx : hit_idx;

        if (flush_all)     st_d.valid = '0;
        if (flush_asid_en) st_d.valid = st_d.valid & ~asid_match;

        if (fill_valid) begin
            st_d.valid[wr_idx]    = 1'b1;
            st_d.ent[wr_idx].vpn  = fill_vpn;
            st_d.ent[wr_idx].asid = fill_asid;
            st_d.ent[wr_idx].pfn  = fill_pfn;
            st_d.ent[wr_idx].perm = perm_e'(fill_perm);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_fault = st_q.rsp_fault;
    assign rsp_pfn   = st_q.rsp_pfn;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !rsp_valid && !rsp_hit && !rsp_fault); // R1
    AST_HIT_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault)); // R4
    AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all && !fill_valid |=> st_q.valid == '0); // R8
    AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && lookup_valid |=> rsp_valid && !rsp_hit && !rsp_fault); // R10

endmodule

// File: tb/tlb_asid_bench.sv
module tlb_asid_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [19:0] lookup_vpn = '0;
    logic [7:0]  lookup_asid = '0;
    logic [1:0]  lookup_acc = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic [1:0]  fill_perm = '0;
    logic        flush_all = 1'b0;
    logic        flush_asid_en = 1'b0;
    logic [7:0]  flush_asid = '0;
    logic        repl_mode = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [19:0] rsp_pfn;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_asid u_tlb_asid (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_vpn(lookup_vpn),
        .lookup_asid(lookup_asid), .lookup_acc(lookup_acc),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en),
        .flush_asid(flush_asid), .repl_mode(repl_mode),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn, input logic [1:0] perm);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
        fill_pfn = pfn; fill_perm = perm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic lookup(input logic [19:0] vpn, input logic [7:0] asid,
                          input logic [1:0] acc, output logic [22:0] res);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_vpn = vpn; lookup_asid = asid; lookup_acc = acc;
        @(negedge clk);
        lookup_valid = 1'b0;
        res = {rsp_valid, rsp_hit, rsp_fault, rsp_pfn};
    endtask

    task automatic expect_lookup(input string req, input logic [19:0] vpn,
                                 input logic [7:0] asid, input logic [1:0] acc,
                                 input logic hit, input logic fault, input logic [19:0] pfn);
        logic [22:0] res;
        lookup(vpn, asid, acc, res);
        check(req, {9'd0, res}, {9'd0, 1'b1, hit, fault, pfn});
    endtask

    task automatic do_flush_all();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 rsp_valid", {31'd0, rsp_valid}, 0);
        check("R11 rsp_hit", {31'd0, rsp_hit}, 0);
        check("R11 rsp_pfn", {12'd0, rsp_pfn}, 0);
        expect_lookup("R11 empty miss", 20'h0, 8'h0, 2'd0, 1'b0, 1'b0, 20'h0);
    endtask

    task automatic t_basic();
        fill(20'h12345, 8'd3, 20'hABCDE, 2'd0);
        expect_lookup("R2 hit", 20'h12345, 8'd3, 2'd0, 1'b1, 1'b0, 20'hABCDE);
        @(negedge clk);
        check("R1 idle no rsp", {29'd0, rsp_valid, rsp_hit, rsp_fault}, 0);
        expect_lookup("R2 vpn miss", 20'h12346, 8'd3, 2'd0, 1'b0, 1'b0, 20'h0);
        expect_lookup("R3 other asid miss", 20'h12345, 8'd4, 2'd0, 1'b0, 1'b0, 20'h0);
        fill(20'h12345, 8'd4, 20'h11111, 2'd0);
        expect_lookup("R3 asid4", 20'h12345, 8'd4, 2'd0, 1'b1, 1'b0, 20'h11111);
        expect_lookup("R3 asid3", 20'h12345, 8'd3, 2'd0, 1'b1, 1'b0, 20'hABCDE);
    endtask

    task automatic t_perm();
        fill(20'h20, 8'd3, 20'h00A20, 2'd1);
        fill(20'h21, 8'd3, 20'h00A21, 2'd2);
        fill(20'h22, 8'd3, 20'h00A22, 2'd3);
        expect_lookup("R4 ro write", 20'h20, 8'd3, 2'd1, 1'b0, 1'b1, 20'h0);
        expect_lookup("R4 ro read", 20'h20, 8'd3, 2'd0, 1'b1, 1'b0, 20'h00A20);
        expect_lookup("R4 xo fetch", 20'h21, 8'd3, 2'd2, 1'b1, 1'b0, 20'h00A21);
        expect_lookup("R4 xo read", 20'h21, 8'd3, 2'd0, 1'b0, 1'b1, 20'h0);
        expect_lookup("R4 rw write", 20'h12345, 8'd3, 2'd1, 1'b1, 1'b0, 20'hABCDE);
        expect_lookup("R4 rw fetch", 20'h12345, 8'd3, 2'd2, 1'b0, 1'b1, 20'h0);
        expect_lookup("R4 none read", 20'h22, 8'd3, 2'd0, 1'b0, 1'b1, 20'h0);
        expect_lookup("R4 bad acc", 20'h12345, 8'd3, 2'd3, 1'b0, 1'b1, 20'h0);
    endtask

    task automatic t_flush_all();
        do_flush_all();
        expect_lookup("R8 miss after flush", 20'h12345, 8'd3, 2'd0, 1'b0, 1'b0, 20'h0);
        expect_lookup("R8 miss after flush b", 20'h21, 8'd3, 2'd2, 1'b0, 1'b0, 20'h0);
    endtask

    task automatic fill_sixteen(input logic [7:0] asid);
        for (int i = 0; i < 16; i++) fill(20'(i), asid, 20'h100 + 20'(i), 2'd0);
    endtask

    task automatic t_dedup();
        do_flush_all();
        fill_sixteen(8'd1);
        fill(20'd5, 8'd1, 20'h55555, 2'd0);
        for (int i = 0; i < 16; i++) begin
            if (i == 5)
                expect_lookup("R5 overwritten", 20'd5, 8'd1, 2'd0, 1'b1, 1'b0, 20'h55555);
            else
                expect_lookup("R5 no eviction", 20'(i), 8'd1, 2'd0, 1'b1, 1'b0, 20'h100 + 20'(i));
        end
    endtask

    task automatic t_lru();
        do_flush_all();
        repl_mode = 1'b0;
        fill_sixteen(8'd1);
        expect_lookup("R6 touch 0", 20'd0, 8'd1, 2'd0, 1'b1, 1'b0, 20'h100);
        fill(20'h300, 8'd1, 20'h33333, 2'd0);
        expect_lookup("R6 lru evicted", 20'd1, 8'd1, 2'd0, 1'b0, 1'b0, 20'h0);
        expect_lookup("R6 touched kept", 20'd0, 8'd1, 2'd0, 1'b1, 1'b0, 20'h100);
        expect_lookup("R6 next kept", 20'd2, 8'd1, 2'd0, 1'b1, 1'b0, 20'h102);
        expect_lookup("R6 new hit", 20'h300, 8'd1, 2'd0, 1'b1, 1'b0, 20'h33333);
    endtask

    task automatic t_random();
        int hits;
        logic [22:0] res;
        do_flush_all();
        fill_sixteen(8'd2);
        repl_mode = 1'b1;
        fill(20'h400, 8'd2, 20'h44444, 2'd0);
        repl_mode = 1'b0;
        hits = 0;
        for (int i = 0; i < 16; i++) begin
            lookup(20'(i), 8'd2, 2'd0, res);
            if (res[21]) hits++;
        end
        check("R7 one evicted", 32'(hits), 32'd15);
        expect_lookup("R7 new hit", 20'h400, 8'd2, 2'd0, 1'b1, 1'b0, 20'h44444);
    endtask

    task automatic t_flush_asid();
        do_flush_all();
        fill(20'h50, 8'd7, 20'h00050, 2'd0);
        fill(20'h51, 8'd8, 20'h00051, 2'd0);
        @(negedge clk);
        flush_asid_en = 1'b1; flush_asid = 8'd7;
        @(negedge clk);
        flush_asid_en = 1'b0;
        expect_lookup("R9 flushed asid", 20'h50, 8'd7, 2'd0, 1'b0, 1'b0, 20'h0);
        expect_lookup("R9 other kept", 20'h51, 8'd8, 2'd0, 1'b1, 1'b0, 20'h00051);
    endtask

    task automatic t_fill_prio();
        @(negedge clk);
        lookup_valid = 1'b1; lookup_vpn = 20'h51; lookup_asid = 8'd8; lookup_acc = 2'd0;
        fill_valid = 1'b1; fill_vpn = 20'h60; fill_asid = 8'd8;
        fill_pfn = 20'h00060; fill_perm = 2'd0;
        @(negedge clk);
        lookup_valid = 1'b0; fill_valid = 1'b0;
        check("R10 lookup miss on fill", {29'd0, rsp_valid, rsp_hit, rsp_fault}, 32'd4);
        expect_lookup("R10 fill landed", 20'h60, 8'd8, 2'd0, 1'b1, 1'b0, 20'h00060);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_perm();
        t_flush_all();
        t_dedup();
        t_lru();
        t_random();
        t_flush_asid();
        t_fill_prio();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule